// File: doc/BRIEF.md
# I2C Bus Deadlock Recovery Sequencer

This block restores an I2C bus that has been left idle and stuck after a master request or a repeated start failed. Both sides may have given up, so the start sequence never finishes and the bus can stay locked. It is started with a one-cycle `go` pulse and then runs a fixed four-step recovery on its own. First it clears the bus-error and bus-busy indications. Next it watches the bus-busy input for a programmable number of system clock cycles, to make sure no other master is active. It then pulses a one-cycle reset into the protocol engine, which puts the engine back in the non-addressed slave state. Last, it takes the bus and sends a Start, one address byte and a Stop, so that every slave sees a complete frame and falls back into step.

The byte-level work is done by a simple bit-level transmitter outside this block. This block sends it one request at a time, each naming a command, and waits for a one-cycle completion pulse before sending the next request. No acknowledge is read back. If another master shows up during the watch window, the sequence stops there and reports an aborted status. Completion is signalled by a one-cycle `done` pulse, with `ok` high for a full recovery and low for an abort.

Top module: `bus_unlock_seq`

## Requirements
- R1: A `go` pulse is accepted only while the sequencer is idle, and `addr_byte` is captured in that cycle. A `go` seen while a sequence is running has no effect: it produces no second clear pulse and does not change the byte that is sent.
- R2: In the cycle after `go` is accepted, `clr_err` and `clr_busy` are both high, for exactly one cycle.
- R3: The watch window lasts TIMEOUT cycles and starts right after the clear cycle. `bus_busy` is sampled only inside that window. A busy level left over during the clear cycle does not abort the sequence.
- R4: If the window passes with `bus_busy` low throughout, `eng_rst` is high for exactly one cycle, in the cycle that follows the last window cycle.
- R5: The cycle after `eng_rst`, a Start request is issued. The transmitter commands are 2'b01 Start, 2'b10 Byte and 2'b11 Stop. Requests go out in the order Start, Byte, Stop, and each `tx_req` is high for one cycle. Each following request appears in the cycle after the one in which `tx_done` is sampled. `tx_data` carries the captured address with the Byte request and is zero with Start and Stop.
- R6: If `bus_busy` is sampled high in any window cycle, including the last one, the next cycle shows `done` with `ok` low. In that case there is no `eng_rst` and no transmitter request.
- R7: A `tx_done` that arrives while no request is outstanding is ignored. `bus_busy` outside the watch window is ignored.
- R8: `done` is a one-cycle pulse. On success it rises in the cycle after the `tx_done` of the Stop request is sampled, with `ok` high. No acknowledge status is consulted. `ok` is low whenever `done` is low.
- R9: During and after reset, with no `go`, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start request for one recovery sequence |
| addr_byte | input | BYTE_W | Byte sent in the dummy frame, captured when `go` is accepted |
| bus_busy | input | 1 | Bus-busy indication from the bus monitor |
| tx_done | input | 1 | One-cycle completion pulse from the bit-level transmitter |
| clr_err | output | 1 | One-cycle pulse that clears the bus-error flag |
| clr_busy | output | 1 | One-cycle pulse that clears the bus-busy flag |
| eng_rst | output | 1 | One-cycle reset pulse into the protocol engine |
| tx_req | output | 1 | One-cycle request to the transmitter |
| tx_cmd | output | 2 | Transmitter command: 01 Start, 10 Byte, 11 Stop |
| tx_data | output | BYTE_W | Byte to send with a Byte command, zero otherwise |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | High with `done` when recovery completed, low on abort |

## Verification
The assertions assume that the transmitter raises `tx_done` at least one cycle after a request, and only while a request is outstanding. They also assume that the flag owner lowers `bus_busy` once the clear pulse has been seen. The bench's transmitter model answers each request after a set latency of one or more cycles. Its busy driver only asserts `bus_busy` inside windows scheduled relative to the `go` cycle. Stray completions and busy levels are injected only where R7 says they must be ignored.

// File: rtl/bus_unlock_pkg.sv
package bus_unlock_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CLEAR = 3'd1,
    S_WAIT  = 3'd2,
    S_RESET = 3'd3,
    S_SEND  = 3'd4,
    S_DONE  = 3'd5
  } seq_st_t;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_START = 2'b01,
    CMD_BYTE  = 2'b10,
    CMD_STOP  = 2'b11
  } tx_cmd_e;

  localparam int unsigned FRAME_STEPS = 3;

  // step 0 -> Start, 1 -> Byte, 2 -> Stop
  function automatic tx_cmd_e cmd_for_step(input logic [1:0] step);
    return tx_cmd_e'(step + 2'd1);
  endfunction

  function automatic logic is_last_step(input logic [1:0] step);
    return step == 2'(FRAME_STEPS - 1);
  endfunction

  function automatic logic carries_data(input logic [1:0] step);
    return cmd_for_step(step) == CMD_BYTE;
  endfunction

  // effective window length: at least two cycles
  function automatic int unsigned window_len(input int unsigned t);
    return (t < 2) ? 2 : t;
  endfunction

endpackage

// File: rtl/bus_unlock_idle_timer.sv
module bus_unlock_idle_timer #(
  parameter int unsigned TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  import bus_unlock_pkg::*;

  localparam int unsigned EFF  = window_len(TIMEOUT);
  localparam int unsigned CW   = $clog2(EFF);
  localparam logic [CW-1:0] LAST = CW'(EFF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign expire = run && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R3
  AST_EXPIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(run)); // R3

endmodule

// File: rtl/bus_unlock_frame_tx.sv
module bus_unlock_frame_tx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [BYTE_W-1:0] addr,
  input  logic              tx_done,
  output logic              tx_req,
  output logic [1:0]        tx_cmd,
  output logic [BYTE_W-1:0] tx_data,
  output logic              fin
);
  import bus_unlock_pkg::*;

  logic              active_q;
  logic [1:0]        step_q;
  logic              req_q;
  tx_cmd_e           cmd_q;
  logic [BYTE_W-1:0] data_q;
  logic [1:0]        step_nx;
  logic              ev_step_done;

  assign ev_step_done = active_q && tx_done;
  assign step_nx      = step_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= '0;
      req_q    <= 1'b0;
      cmd_q    <= CMD_NONE;
      data_q   <= '0;
    end else begin
      req_q <= 1'b0;
      if (!active_q) begin
        if (launch) begin
          active_q <= 1'b1;
          step_q   <= '0;
          req_q    <= 1'b1;
          cmd_q    <= cmd_for_step(2'd0);
          data_q   <= '0;
        end
      end else if (ev_step_done) begin
        if (is_last_step(step_q)) begin
          active_q <= 1'b0;
        end else begin
          step_q <= step_nx;
          req_q  <= 1'b1;
          cmd_q  <= cmd_for_step(step_nx);
          data_q <= carries_data(step_nx) ? addr : '0;
        end
      end
    end
  end

  assign fin     = ev_step_done && is_last_step(step_q);
  assign tx_req  = req_q;
  assign tx_cmd  = cmd_q;
  assign tx_data = data_q;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R5
  AST_FIN_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (cmd_q == CMD_STOP)); // R5
  AST_BYTE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && cmd_q == CMD_BYTE) |-> $past(cmd_q) == CMD_START); // R5

endmodule

// File: rtl/bus_unlock_seq.sv
module bus_unlock_seq #(
  parameter int unsigned TIMEOUT = 1000,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              bus_busy,
  input  logic              tx_done,
  output logic              clr_err,
  output logic              clr_busy,
  output logic              eng_rst,
  output logic              tx_req,
  output logic [1:0]        tx_cmd,
  output logic [BYTE_W-1:0] tx_data,
  output logic              done,
  output logic              ok
);
  import bus_unlock_pkg::*;

  seq_st_t           st_q, st_d;
  logic              ok_q, ok_d;
  logic [BYTE_W-1:0] addr_q;

  // named internal events
  logic ev_accept;
  logic ev_abort;
  logic ev_expire;
  logic ev_sent;
  logic in_window;
  logic launch;

  assign in_window = (st_q == S_WAIT);
  assign ev_accept = (st_q == S_IDLE) && go;
  assign ev_abort  = in_window && bus_busy;
  assign launch    = (st_q == S_RESET);

  bus_unlock_idle_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_window),
    .expire (ev_expire)
  );

  bus_unlock_frame_tx #(.BYTE_W(BYTE_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .addr    (addr_q),
    .tx_done (tx_done),
    .tx_req  (tx_req),
    .tx_cmd  (tx_cmd),
    .tx_data (tx_data),
    .fin     (ev_sent)
  );

  always_comb begin
    st_d = st_q;
    ok_d = ok_q;
    unique case (st_q)
      S_IDLE:  if (ev_accept) st_d = S_CLEAR;
      S_CLEAR: st_d = S_WAIT;
      S_WAIT: begin
        if (ev_abort) begin
          st_d = S_DONE;
          ok_d = 1'b0;
        end else if (ev_expire) begin
          st_d = S_RESET;
        end
      end
      S_RESET: st_d = S_SEND;
      S_SEND: begin
        if (ev_sent) begin
          st_d = S_DONE;
          ok_d = 1'b1;
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ok_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      ok_q <= ok_d;
      if (ev_accept) addr_q <= addr_byte;
    end
  end

  assign clr_err  = (st_q == S_CLEAR);
  assign clr_busy = (st_q == S_CLEAR);
  assign eng_rst  = (st_q == S_RESET);
  assign done     = (st_q == S_DONE);
  assign ok       = done && ok_q;

  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !clr_err && !clr_busy); // R2
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> clr_err && clr_busy); // R2
  AST_EXPIRE_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_expire && !bus_busy) |=> eng_rst); // R4
  AST_RESET_THEN_START: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> !eng_rst && tx_req && tx_cmd == CMD_START); // R4
  AST_NO_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> !tx_req); // R5
  AST_ABORT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> done && !ok && !eng_rst); // R6
  AST_SENT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sent |=> done && ok); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done); // R8

endmodule

// File: tb/sim_bus_unlock_seq.sv
module sim_bus_unlock_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T = 20;
  localparam int WDOG = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [7:0] addr_byte = 8'h00;
  logic bus_busy = 1'b0;
  logic tx_done = 1'b0;
  logic clr_err, clr_busy, eng_rst, tx_req, done, ok;
  logic [1:0] tx_cmd;
  logic [7:0] tx_data;

  bus_unlock_seq #(.TIMEOUT(T), .BYTE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .addr_byte(addr_byte),
    .bus_busy(bus_busy), .tx_done(tx_done), .clr_err(clr_err),
    .clr_busy(clr_busy), .eng_rst(eng_rst), .tx_req(tx_req),
    .tx_cmd(tx_cmd), .tx_data(tx_data), .done(done), .ok(ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // stimulus schedule and monitor log
  int tx_lat = 1;
  int pend = 0;
  int busy_from = -1, busy_to = -1;
  int spur_at = -1;
  int n_clr, clr_cyc, n_rst, rst_cyc, n_req, n_done, done_cyc, done_ok;
  int req_cyc[8];
  int req_cmd[8];
  int req_dat[8];

  always @(negedge clk) begin
    bus_busy = (cyc >= busy_from) && (cyc <= busy_to);
    tx_done = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) tx_done = 1'b1;
    end
    if (cyc == spur_at) tx_done = 1'b1;
    if (rst_n) begin
      if (clr_err && clr_busy) begin n_clr++; clr_cyc = cyc; end
      if (eng_rst) begin n_rst++; rst_cyc = cyc; end
      if (tx_req) begin
        if (n_req < 8) begin
          req_cyc[n_req] = cyc; req_cmd[n_req] = int'(tx_cmd); req_dat[n_req] = int'(tx_data);
        end
        n_req++;
        pend = tx_lat;
      end
      if (done) begin n_done++; done_cyc = cyc; done_ok = int'(ok); end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    n_clr = 0; n_rst = 0; n_req = 0; n_done = 0;
    clr_cyc = -1; rst_cyc = -1; done_cyc = -1; done_ok = -1;
    busy_from = -1; busy_to = -1; spur_at = -1; pend = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && n_done == 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // expect a full recovery that started with go seen at negedge c0
  task automatic expect_success(input string tag, input int c0, input int lat, input int addr);
    int r0;
    r0 = c0 + T + 3;
    chk({tag, " R2 clear count"}, n_clr, 1);
    chk({tag, " R2 clear cycle"}, clr_cyc, c0 + 1);
    chk({tag, " R4 reset count"}, n_rst, 1);
    chk({tag, " R4 reset cycle"}, rst_cyc, c0 + T + 2);
    chk({tag, " R5 request count"}, n_req, 3);
    chk({tag, " R5 start cycle"}, req_cyc[0], r0);
    chk({tag, " R5 start cmd"}, req_cmd[0], 1);
    chk({tag, " R5 start data"}, req_dat[0], 0);
    chk({tag, " R5 byte cycle"}, req_cyc[1], r0 + lat + 1);
    chk({tag, " R5 byte cmd"}, req_cmd[1], 2);
    chk({tag, " R1 byte data"}, req_dat[1], addr);
    chk({tag, " R5 stop cycle"}, req_cyc[2], r0 + 2 * (lat + 1));
    chk({tag, " R5 stop cmd"}, req_cmd[2], 3);
    chk({tag, " R5 stop data"}, req_dat[2], 0);
    chk({tag, " R8 done count"}, n_done, 1);
    chk({tag, " R8 done cycle"}, done_cyc, r0 + 3 * (lat + 1));
    chk({tag, " R8 ok"}, done_ok, 1);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 outputs in reset", int'({clr_err, clr_busy, eng_rst, tx_req, done, ok, tx_cmd, tx_data}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 outputs after reset", int'({clr_err, clr_busy, eng_rst, tx_req, done, ok, tx_cmd, tx_data}), 0);
  endtask

  task automatic test_basic(input int addr, input int lat);
    int c0;
    clear_log();
    tx_lat = lat;
    @(negedge clk);
    c0 = cyc;
    addr_byte = 8'(addr); go = 1'b1;
    @(negedge clk); go = 1'b0;
    wait_done();
    expect_success("basic", c0, lat, addr);
  endtask

  task automatic test_go_held_addr_change();
    int c0;
    clear_log();
    tx_lat = 4;
    @(negedge clk);
    c0 = cyc;
    addr_byte = 8'h3C; go = 1'b1;
    @(negedge clk); addr_byte = 8'hFF;
    @(negedge clk); addr_byte = 8'h11;
    @(negedge clk); go = 1'b0;
    wait_done();
    expect_success("go_held R1", c0, 4, 8'h3C);
  endtask

  task automatic test_stale_busy();
    int c0;
    clear_log();
    tx_lat = 2;
    @(negedge clk);
    c0 = cyc;
    busy_from = c0; busy_to = c0 + 1;
    addr_byte = 8'h5A; go = 1'b1;
    @(negedge clk); go = 1'b0;
    wait_done();
    expect_success("stale_busy R3", c0, 2, 8'h5A);
  endtask

  task automatic test_abort(input int k);
    int c0;
    clear_log();
    tx_lat = 1;
    @(negedge clk);
    c0 = cyc;
    busy_from = c0 + 1 + k; busy_to = c0 + 1 + k;
    addr_byte = 8'h77; go = 1'b1;
    @(negedge clk); go = 1'b0;
    wait_done();
    chk("abort R2 clear count", n_clr, 1);
    chk("abort R6 no reset", n_rst, 0);
    chk("abort R6 no request", n_req, 0);
    chk("abort R6 done count", n_done, 1);
    chk("abort R6 done cycle", done_cyc, c0 + 2 + k);
    chk("abort R6 ok low", done_ok, 0);
  endtask

  task automatic test_ignored_inputs();
    int c0;
    clear_log();
    tx_lat = 3;
    @(negedge clk);
    c0 = cyc;
    spur_at = c0 + 6;
    busy_from = c0 + T + 3; busy_to = c0 + T + 8;
    addr_byte = 8'hC3; go = 1'b1;
    @(negedge clk); go = 1'b0;
    wait_done();
    expect_success("ignored R7", c0, 3, 8'hC3);
  endtask

  initial begin
    for (int i = 0; i < WDOG; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_log();
    test_reset();
    test_basic(8'hA5, 1);
    test_go_held_addr_change();
    test_stale_busy();
    test_abort(1);
    test_abort(T);
    test_ignored_inputs();
    test_basic(8'h00, 5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule